// File: doc/BRIEF.md
# Tagged capability memory store

This block is a small on-chip store of slots. Each slot holds either one capability or two independent data words. A slot is CLEN = 2*CXLEN data bits wide. Beside it sits one hidden validity tag bit. The tag says whether the slot currently holds a capability (1) or plain data (0). A capability store writes both halves and the tag in one step. Any narrower data store clears the tag. Ordinary data written through the narrow path can therefore never be turned into a capability.

The single request port takes one access per cycle, addressed by byte. A capability access moves a whole slot and must be aligned to the slot size; a misaligned one is rejected with an error pulse. A data access moves one CXLEN-bit word with byte enables. Address bit log2(CXLEN/8) selects the word: 0 is the lower-addressed half, which holds the capability's address, and 1 is the higher-addressed half, which holds its metadata. Every read returns the tag, both halves and the selected word one clock later.

Top module: `capmem_store`

## Requirements
- R1: An aligned capability write stores both halves and the tag at once. A following read of that slot returns the metadata on rsp_meta, the address on rsp_addr, and rsp_tag equal to the req_wtag that was written, whether 0 or 1.
- R2: A capability access (read or write) whose byte address is not a multiple of CLEN/8 raises rsp_err for exactly one cycle, in the cycle after the request, and produces no rsp_valid.
- R3: A rejected misaligned capability write leaves both halves and the tag of every slot unchanged.
- R4: The address half is held in the lower-addressed word (word-select bit 0) and the metadata half in the higher-addressed word (word-select bit 1). A data read of a slot returns that word on rsp_word.
- R5: A data write changes only the selected word; the other half of the slot keeps its value.
- R6: Any data write clears its slot's tag, whatever the selected half and even with all byte enables at 0; the next read shows tag 0.
- R7: In a data write, byte lane b of the selected word changes only when req_be[b] is 1.
- R8: A read is answered by rsp_valid exactly one clock after the request, and only for reads. A read issued in the cycle right after a write to the same slot returns the newly written value.
- R9: After reset every slot's tag reads 0.
- R10: Data accesses never raise rsp_err. Byte-address bits below the word size are ignored for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cap | input | 1 | 1 = full capability access, 0 = word data access |
| req_addr | input | $clog2(DEPTH)+$clog2(CXLEN/8)+1 | Byte address |
| req_wcap | input | 2*CXLEN | Capability write value {metadata, address} |
| req_wtag | input | 1 | Tag written by a capability write |
| req_wdata | input | CXLEN | Data write word |
| req_be | input | CXLEN/8 | Byte enables for data writes |
| rsp_valid | output | 1 | Read response present |
| rsp_err | output | 1 | Misaligned capability access rejected |
| rsp_tag | output | 1 | Tag of the slot read |
| rsp_meta | output | CXLEN | Metadata (higher) half of the slot read |
| rsp_addr | output | CXLEN | Address (lower) half of the slot read |
| rsp_word | output | CXLEN | Word chosen by the word-select address bit |

## Verification
The bench uses the default parameters: CXLEN = 32 and DEPTH = 16. That gives 8-byte slots, 4-bit byte enables and a 7-bit address. Every slot can be visited for the reset tag check. Each misaligned offset class lies within easy reach: a word offset of 4, sub-word offsets, and sub-word offsets on data accesses that must be ignored. With 4 byte lanes, a sparse enable pattern shows partial merges, and an all-zero pattern probes the tag-clear rule.

// File: rtl/capmem_pkg.sv
package capmem_pkg;
  // decoded operation for one cycle
  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_READ    = 2'd1,
    OP_WR_CAP  = 2'd2,
    OP_WR_DATA = 2'd3
  } capmem_op_e;
endpackage

// File: rtl/capmem_rst_sync.sv
module capmem_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/capmem_decode.sv
module capmem_decode
  import capmem_pkg::*;
#(
  parameter int CXLEN = 32,
  parameter int DEPTH = 16,
  localparam int WB   = CXLEN / 8,
  localparam int WOFF = $clog2(WB),
  localparam int SOFF = WOFF + 1,
  localparam int IW   = $clog2(DEPTH),
  localparam int AW   = IW + SOFF
) (
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_cap,
  input  logic [AW-1:0] req_addr,
  output capmem_op_e    op,
  output logic [IW-1:0] slot,
  output logic          half_sel,
  output logic          bad_align
);
  logic sub_slot_bits;

  always_comb begin
    sub_slot_bits = (req_addr[SOFF-1:0] != '0);
    bad_align     = req_valid && req_cap && sub_slot_bits;
    slot          = req_addr[SOFF +: IW];
    half_sel      = req_addr[WOFF];
    if (!req_valid || bad_align) op = OP_IDLE;
    else if (!req_write)         op = OP_READ;
    else if (req_cap)            op = OP_WR_CAP;
    else                         op = OP_WR_DATA;
  end
endmodule

// File: rtl/capmem_tag_array.sv
module capmem_tag_array
  import capmem_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  capmem_op_e    op,
  input  logic [IW-1:0] slot,
  input  logic          wtag,
  output logic          rd_tag
);
  logic [DEPTH-1:0] tag_q, tag_d;
  logic             tag_en;
  logic             rd_en;
  logic             rd_tag_q, rd_tag_d;

  always_comb begin
    tag_d  = tag_q;
    tag_en = 1'b0;
    if (op == OP_WR_CAP) begin
      tag_d[slot] = wtag;
      tag_en      = 1'b1;
    end else if (op == OP_WR_DATA) begin
      tag_d[slot] = 1'b0;
      tag_en      = 1'b1;
    end
    rd_en    = (op == OP_READ);
    rd_tag_d = tag_q[slot];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q    <= '0;
      rd_tag_q <= 1'b0;
    end else begin
      if (tag_en) tag_q    <= tag_d;
      if (rd_en)  rd_tag_q <= rd_tag_d;
    end
  end

  assign rd_tag = rd_tag_q;
endmodule

// File: rtl/capmem_data_array.sv
module capmem_data_array
  import capmem_pkg::*;
#(
  parameter int CXLEN = 32,
  parameter int DEPTH = 16,
  localparam int CLEN = 2 * CXLEN,
  localparam int WB   = CXLEN / 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  capmem_op_e       op,
  input  logic [IW-1:0]    slot,
  input  logic             half_sel,
  input  logic [CLEN-1:0]  wcap,
  input  logic [CXLEN-1:0] wdata,
  input  logic [WB-1:0]    be,
  output logic [CXLEN-1:0] rd_lo,
  output logic [CXLEN-1:0] rd_hi
);
  logic [CLEN-1:0] rd_all;
  logic            rd_en;

  assign rd_en = (op == OP_READ);

  for (genvar h = 0; h < 2; h++) begin : g_half
    for (genvar b = 0; b < WB; b++) begin : g_lane
      logic [7:0] lane_mem [DEPTH];
      logic [7:0] lane_rd_q;
      logic [7:0] lane_wb;
      logic       lane_we;

      always_comb begin
        lane_we = (op == OP_WR_CAP) ||
                  ((op == OP_WR_DATA) && (half_sel == 1'(h)) && be[b]);
        lane_wb = (op == OP_WR_CAP) ? wcap[h*CXLEN + b*8 +: 8] : wdata[b*8 +: 8];
      end

      always_ff @(posedge clk) begin
        if (lane_we) lane_mem[slot] <= lane_wb;
      end

      always_ff @(posedge clk) begin
        if (rd_en) lane_rd_q <= lane_mem[slot];
      end

      assign rd_all[h*CXLEN + b*8 +: 8] = lane_rd_q;
    end
  end

  assign rd_lo = rd_all[CXLEN-1:0];
  assign rd_hi = rd_all[CLEN-1:CXLEN];
endmodule

// File: rtl/capmem_store.sv
module capmem_store
  import capmem_pkg::*;
#(
  parameter int CXLEN = 32,
  parameter int DEPTH = 16,
  localparam int CLEN = 2 * CXLEN,
  localparam int WB   = CXLEN / 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int AW   = IW + $clog2(WB) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_cap,
  input  logic [AW-1:0]    req_addr,
  input  logic [CLEN-1:0]  req_wcap,
  input  logic             req_wtag,
  input  logic [CXLEN-1:0] req_wdata,
  input  logic [WB-1:0]    req_be,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic             rsp_tag,
  output logic [CXLEN-1:0] rsp_meta,
  output logic [CXLEN-1:0] rsp_addr,
  output logic [CXLEN-1:0] rsp_word
);
  logic          rst_n_s;
  capmem_op_e    op;
  logic [IW-1:0] slot;
  logic          half_sel;
  logic          bad_align;

  logic rsp_valid_q, rsp_valid_d;
  logic err_q, err_d;
  logic half_q, half_d;
  logic half_en;

  capmem_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  capmem_decode #(.CXLEN(CXLEN), .DEPTH(DEPTH)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_cap   (req_cap),
    .req_addr  (req_addr),
    .op        (op),
    .slot      (slot),
    .half_sel  (half_sel),
    .bad_align (bad_align)
  );

  capmem_tag_array #(.DEPTH(DEPTH)) u_tags (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .op     (op),
    .slot   (slot),
    .wtag   (req_wtag),
    .rd_tag (rsp_tag)
  );

  capmem_data_array #(.CXLEN(CXLEN), .DEPTH(DEPTH)) u_data (
    .clk      (clk),
    .op       (op),
    .slot     (slot),
    .half_sel (half_sel),
    .wcap     (req_wcap),
    .wdata    (req_wdata),
    .be       (req_be),
    .rd_lo    (rsp_addr),
    .rd_hi    (rsp_meta)
  );

  always_comb begin
    rsp_valid_d = (op == OP_READ);
    err_d       = bad_align;
    half_d      = half_sel;
    half_en     = (op == OP_READ);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rsp_valid_q <= 1'b0;
      err_q       <= 1'b0;
      half_q      <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      err_q       <= err_d;
      if (half_en) half_q <= half_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = err_q;
  assign rsp_word  = half_q ? rsp_meta : rsp_addr;
endmodule

// File: rtl/capmem_store_chk.sv
module capmem_store_chk #(
  parameter int CXLEN = 32,
  parameter int DEPTH = 16,
  localparam int CLEN = 2 * CXLEN,
  localparam int WB   = CXLEN / 8,
  localparam int SOFF = $clog2(WB) + 1,
  localparam int IW   = $clog2(DEPTH),
  localparam int AW   = IW + SOFF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic             req_cap,
  input logic [AW-1:0]    req_addr,
  input logic [CLEN-1:0]  req_wcap,
  input logic             req_wtag,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic             rsp_tag,
  input logic [CXLEN-1:0] rsp_meta,
  input logic [CXLEN-1:0] rsp_addr
);
  logic          off_nz;
  logic [IW-1:0] cur_slot;
  logic          good_read;
  logic          good_cap_wr;
  logic          data_wr;

  assign off_nz      = (req_addr[SOFF-1:0] != '0);
  assign cur_slot    = req_addr[SOFF +: IW];
  assign good_read   = req_valid && !req_write && !(req_cap && off_nz);
  assign good_cap_wr = req_valid && req_write && req_cap && !off_nz;
  assign data_wr     = req_valid && req_write && !req_cap;

  assert_err_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> $past(req_valid && req_cap && off_nz));

  assert_err_no_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_err && rsp_valid));

  assert_rsp_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(good_read));

  assert_read_answered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    good_read |=> rsp_valid);

  assert_data_clears_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (good_read && $past(data_wr) && (cur_slot == $past(cur_slot)))
    |=> (rsp_valid && !rsp_tag));

  assert_cap_roundtrip_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (good_read && $past(good_cap_wr) && (cur_slot == $past(cur_slot)))
    |=> ((rsp_tag == $past(req_wtag, 2)) && ({rsp_meta, rsp_addr} == $past(req_wcap, 2))));
endmodule

bind capmem_store capmem_store_chk #(.CXLEN(CXLEN), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_cap   (req_cap),
  .req_addr  (req_addr),
  .req_wcap  (req_wcap),
  .req_wtag  (req_wtag),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_tag   (rsp_tag),
  .rsp_meta  (rsp_meta),
  .rsp_addr  (rsp_addr)
);

// File: tb/tb_capmem_store.sv
module tb_capmem_store;
  localparam int CXLEN = 32;
  localparam int DEPTH = 16;
  localparam int CLEN  = 2 * CXLEN;
  localparam int WB    = CXLEN / 8;
  localparam int AW    = $clog2(DEPTH) + $clog2(WB) + 1;

  logic             clk;
  logic             rst_n;
  logic             req_valid, req_write, req_cap, req_wtag;
  logic [AW-1:0]    req_addr;
  logic [CLEN-1:0]  req_wcap;
  logic [CXLEN-1:0] req_wdata;
  logic [WB-1:0]    req_be;
  logic             rsp_valid, rsp_err, rsp_tag;
  logic [CXLEN-1:0] rsp_meta, rsp_addr, rsp_word;

  capmem_store #(.CXLEN(CXLEN), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_cap(req_cap),
    .req_addr(req_addr), .req_wcap(req_wcap), .req_wtag(req_wtag),
    .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_tag(rsp_tag),
    .rsp_meta(rsp_meta), .rsp_addr(rsp_addr), .rsp_word(rsp_word)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    bit               is_err;
    bit               tag;
    bit               k_lo;
    bit               k_hi;
    logic [CXLEN-1:0] lo;
    logic [CXLEN-1:0] hi;
    bit               half;
    string            rq;
  } exp_t;

  exp_t q[$];
  int   checks   = 0;
  int   failures = 0;
  bit   mon_on   = 0;
  bit   done     = 0;

  bit               m_tag [DEPTH];
  bit               m_klo [DEPTH];
  bit               m_khi [DEPTH];
  logic [CXLEN-1:0] m_lo  [DEPTH];
  logic [CXLEN-1:0] m_hi  [DEPTH];

  task automatic chk(bit ok, string rq, string what, logic [CLEN-1:0] act, logic [CLEN-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk_addr(int s, int h, int off);
    return AW'(s * (2 * WB) + h * WB + off);
  endfunction

  task automatic issue(bit wr, bit cap, logic [AW-1:0] a, logic [CLEN-1:0] wc, bit wt,
                       logic [CXLEN-1:0] wd, logic [WB-1:0] be);
    req_valid = 1'b1; req_write = wr; req_cap = cap; req_addr = a;
    req_wcap = wc; req_wtag = wt; req_wdata = wd; req_be = be;
  endtask

  task automatic finish_req(bit push, exp_t e);
    @(posedge clk);
    if (push) q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cap_write(int s, int off, bit tag, logic [CLEN-1:0] v, string rq);
    exp_t e;
    e = '{default: 0};
    issue(1, 1, mk_addr(s, 0, off), v, tag, '0, '0);
    if (off % (2 * WB) != 0) begin
      e.is_err = 1; e.rq = rq;
      finish_req(1, e);
    end else begin
      m_tag[s] = tag; m_lo[s] = v[CXLEN-1:0]; m_hi[s] = v[CLEN-1:CXLEN];
      m_klo[s] = 1; m_khi[s] = 1;
      finish_req(0, e);
    end
  endtask

  task automatic data_write(int s, int h, int off, logic [WB-1:0] be, logic [CXLEN-1:0] v);
    exp_t e;
    e = '{default: 0};
    issue(1, 0, mk_addr(s, h, off), '0, 1'b1, v, be);
    for (int b = 0; b < WB; b++) begin
      if (be[b]) begin
        if (h == 0) m_lo[s][b*8 +: 8] = v[b*8 +: 8];
        else        m_hi[s][b*8 +: 8] = v[b*8 +: 8];
      end
    end
    if (be == '1) begin
      if (h == 0) m_klo[s] = 1; else m_khi[s] = 1;
    end
    m_tag[s] = 0;
    finish_req(0, e);
  endtask

  task automatic rd(int s, int h, int off, bit cap, string rq);
    exp_t e;
    issue(0, cap, mk_addr(s, h, off), '0, 1'b0, '0, '0);
    e.is_err = cap && ((h * WB + off) % (2 * WB) != 0);
    e.tag = m_tag[s]; e.k_lo = m_klo[s]; e.k_hi = m_khi[s];
    e.lo = m_lo[s]; e.hi = m_hi[s]; e.half = 1'(h); e.rq = rq;
    finish_req(1, e);
  endtask

  // monitor: compare responses against scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (rsp_valid || rsp_err) begin
        if (q.size() == 0) begin
          chk(0, "R8", "unexpected response", {62'd0, rsp_valid, rsp_err}, '0);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.is_err) begin
            chk(rsp_err && !rsp_valid, e.rq, "error pulse", {62'd0, rsp_err, rsp_valid}, 64'h2);
          end else begin
            chk(rsp_valid && !rsp_err, e.rq, "read valid", {62'd0, rsp_valid, rsp_err}, 64'h2);
            chk(rsp_tag == e.tag, e.rq, "tag", 64'(rsp_tag), 64'(e.tag));
            if (e.k_lo) chk(rsp_addr == e.lo, e.rq, "address half", 64'(rsp_addr), 64'(e.lo));
            if (e.k_hi) chk(rsp_meta == e.hi, e.rq, "metadata half", 64'(rsp_meta), 64'(e.hi));
            if (e.half ? e.k_hi : e.k_lo)
              chk(rsp_word == (e.half ? e.hi : e.lo), e.rq, "word",
                  64'(rsp_word), 64'(e.half ? e.hi : e.lo));
          end
        end
      end else if (q.size() != 0) begin
        chk(0, q[0].rq, "missing response", 64'(q.size()), 64'd0);
        void'(q.pop_front());
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    req_valid = 0; req_write = 0; req_cap = 0; req_addr = '0;
    req_wcap = '0; req_wtag = 0; req_wdata = '0; req_be = '0;
    for (int i = 0; i < DEPTH; i++) begin
      m_tag[i] = 0; m_klo[i] = 0; m_khi[i] = 0; m_lo[i] = '0; m_hi[i] = '0;
    end
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!rsp_valid && !rsp_err, "R9", "idle outputs after reset",
        {62'd0, rsp_valid, rsp_err}, '0);
    mon_on = 1;

    // R9: every tag is clear after reset
    for (int s = 0; s < DEPTH; s++) rd(s, 0, 0, 1, "R9");

    // R1 + R4: tagged capability round trip and half placement
    cap_write(3, 0, 1, {32'hA5A5_0001, 32'h1234_5678}, "R1");
    rd(3, 0, 0, 1, "R1");
    rd(3, 0, 0, 0, "R4");
    rd(3, 1, 0, 0, "R4");
    // R1: untagged capability write keeps tag 0
    cap_write(4, 0, 0, {32'h0BAD_F00D, 32'hCAFE_0004}, "R1");
    rd(4, 0, 0, 1, "R1");

    // R5 + R6: data write to address half clears tag, metadata kept
    data_write(3, 0, 0, 4'hF, 32'hDEAD_BEEF);
    rd(3, 0, 0, 1, "R5");
    rd(3, 1, 0, 0, "R6");

    // R6: all-zero byte enables still clear the tag
    cap_write(5, 0, 1, {32'h5555_AAAA, 32'h0000_5000}, "R6");
    rd(5, 0, 0, 1, "R6");
    data_write(5, 1, 0, 4'h0, 32'hFFFF_FFFF);
    rd(5, 0, 0, 1, "R6");

    // R6: metadata-half write also clears the tag
    cap_write(8, 0, 1, {32'h8888_0008, 32'h8000_0000}, "R6");
    data_write(8, 1, 0, 4'hF, 32'h0101_0101);
    rd(8, 1, 0, 1, "R6");

    // R7: sparse byte enables
    data_write(6, 1, 0, 4'hF, 32'h1122_3344);
    data_write(6, 1, 0, 4'b0101, 32'hAABB_CCDD);
    rd(6, 1, 0, 0, "R7");

    // R2 + R3: misaligned capability accesses rejected, memory intact
    cap_write(9, 0, 1, {32'h9999_0009, 32'h9000_0090}, "R3");
    cap_write(9, WB, 1, {32'h0, 32'h0}, "R2");
    rd(9, 0, 0, 1, "R3");
    cap_write(9, 1, 0, {32'h1, 32'h1}, "R2");
    rd(9, 0, 0, 1, "R3");
    rd(9, 0, 3, 1, "R2");
    rd(9, 1, 0, 1, "R2");

    // R10: sub-word offsets on data accesses are ignored, no error
    rd(9, 1, 3, 0, "R10");
    data_write(10, 0, 2, 4'hF, 32'h7777_1010);
    rd(10, 0, 1, 0, "R10");

    // R8: back-to-back write then read of the same slot
    cap_write(7, 0, 1, {32'h7070_7070, 32'h0707_0707}, "R8");
    rd(7, 0, 0, 1, "R8");
    data_write(7, 1, 0, 4'hF, 32'h1357_9BDF);
    rd(7, 1, 0, 0, "R8");

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R8", "outstanding responses", 64'(q.size()), 64'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule